// File: doc/BRIEF.md
# Clock divider synchronization controller

This block drives a bank of programmable channel clock dividers from one divider input clock. It holds every divider in a static, low state while any synchronization request is pending. Once the last request is withdrawn, it restarts all channels on the same clock edge, so that their divided outputs are phase-aligned.

A request can come from any of six sources. Three are asynchronous pins: an active-low sync pin, an active-low power-down pin and a VCO-calibration busy flag. The active-low reset pin also resets the block, and its release counts as a sync event. The remaining sources are three software bits, written through a simple address/data write port. The software bits and the channel ratios are first written to shadow copies. They reach the active logic only when an update strobe is written, and that strobe clears itself.

Because the combined request is asynchronous to the divider clock, it passes through a two-flop synchronizer and then a release counter. The first aligned output edge therefore appears 14 to 15 divider-clock cycles after the request is released.

Top module: `dsync_ctrl`

## Requirements
- R1: While any request source is active, every bit of `divclk` is held low. The sources are `sync_n` low, `pd_n` low, `cal_busy` high, or an active soft-sync, distribution-power-down or soft-reset bit. Release happens only when the last of them goes inactive.
- R2: While `rst_n` is low, all registers are cleared and `divclk` is low. The rising edge of `rst_n` starts a release exactly like a sync release.
- R3: Counting the first rising clock edge at which the combined request is sampled inactive as edge 1, all outputs rise at edge 15. This is 14 to 15 clock cycles after an asynchronous release.
- R4: At the first rising edge after a release, every channel output goes high on the same clock edge.
- R5: Each channel has a ratio code in bits [4:0] of register 0x100+channel. Code c selects divide-by-(c+1), and code 0 selects divide-by-2. Each output period is high for ceil(N/2) cycles and then low for the remainder. After reset, every channel divides by 2.
- R6: Three software bits act as requests: soft sync at register 0x230 bit 0, distribution power-down at 0x230 bit 1, and soft reset at 0x000 bit 2. Writes to them change only shadow copies. A write of 1 to register 0x232 bit 0 copies all shadows to the active copies on the next clock edge. Setting and then clearing a bit this way performs a sync.
- R7: The update strobe clears itself after a single copy. Shadow writes made after that copy have no effect until the strobe is written again.
- R8: A channel loads a newly committed ratio only while it is held. A ratio committed while the channel is running leaves its output unchanged until the next sync.
- R9: A high `cal_busy` holds the outputs for the whole calibration. Its fall releases them with the R3 latency.
- R10: Writes to other bits of register 0x230, or to unused addresses, followed by an update have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider input clock |
| rst_n | input | 1 | Asynchronous active-low reset pin, also a sync source |
| sync_n | input | 1 | Asynchronous active-low sync request pin |
| pd_n | input | 1 | Asynchronous active-low power-down pin |
| cal_busy | input | 1 | High while a VCO calibration runs |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 10 | Register write address |
| wr_data | input | 8 | Register write data |
| divclk | output | NCH | Divided, phase-aligned channel clocks |

## Verification
A wrong state in the synchronizer or release counter shows at the ports as a shifted restart: the first aligned edge arrives earlier or later than the fifteenth edge, and the per-cycle model flags it on that cycle. A channel whose phase counter or latched ratio is wrong gives a high or low time that differs from the model within one output period. A stuck update strobe or a shadow/active mix-up shows up as a hold or restart that starts or fails to start two edges after the register write, which happens well before the next directed window ends.

// File: rtl/dsync_pkg.sv
package dsync_pkg;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam int CODE_W = 5;

  localparam logic [ADDR_W-1:0] A_SOFTRST = 10'h000;
  localparam logic [ADDR_W-1:0] A_DIST    = 10'h230;
  localparam logic [ADDR_W-1:0] A_UPD     = 10'h232;
  localparam logic [ADDR_W-1:0] A_RATIO   = 10'h100;

  localparam int B_SOFTSYNC = 0;
  localparam int B_DISTPD   = 1;
  localparam int B_SOFTRST  = 2;
  localparam int B_UPD      = 0;

  // divide length selected by a ratio code; code 0 is clamped to 2
  function automatic logic [CODE_W:0] div_len(input logic [CODE_W-1:0] code);
    if (code == '0) return (CODE_W+1)'(2);
    return {1'b0, code} + 1'b1;
  endfunction

  // number of high cycles in one output period: ceil(n/2)
  function automatic logic [CODE_W:0] high_len(input logic [CODE_W:0] n);
    return (CODE_W+1)'((n + 1'b1) >> 1);
  endfunction
endpackage

// File: rtl/dsync_regs.sv
module dsync_regs
  import dsync_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic                     soft_sync,
  output logic                     dist_pd,
  output logic                     soft_rst,
  output logic [NCH*CODE_W-1:0]    ratio_code,
  output logic                     upd_pend
);
  logic                  sh_sync, sh_pd, sh_rst;
  logic [NCH*CODE_W-1:0] sh_code;
  logic                  upd_hit;

  assign upd_hit = wr_en && (wr_addr == A_UPD) && wr_data[B_UPD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_sync    <= 1'b0;
      sh_pd      <= 1'b0;
      sh_rst     <= 1'b0;
      sh_code    <= '0;
      soft_sync  <= 1'b0;
      dist_pd    <= 1'b0;
      soft_rst   <= 1'b0;
      ratio_code <= '0;
      upd_pend   <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_DIST) begin
        sh_sync <= wr_data[B_SOFTSYNC];
        sh_pd   <= wr_data[B_DISTPD];
      end
      if (wr_en && wr_addr == A_SOFTRST) sh_rst <= wr_data[B_SOFTRST];
      for (int ch = 0; ch < NCH; ch++) begin
        if (wr_en && wr_addr == A_RATIO + ADDR_W'(ch))
          sh_code[ch*CODE_W +: CODE_W] <= wr_data[CODE_W-1:0];
      end
      // strobe lives one cycle per write: self-clearing
      upd_pend <= upd_hit;
      if (upd_pend) begin
        soft_sync  <= sh_sync;
        dist_pd    <= sh_pd;
        soft_rst   <= sh_rst;
        ratio_code <= sh_code;
      end
    end
  end
endmodule

// File: rtl/dsync_release.sv
module dsync_release #(
  parameter int SYNC_LAT = 15,
  parameter int CNT_END  = SYNC_LAT - 3,
  parameter int CNT_W    = $clog2(CNT_END + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  output logic             held,
  output logic             run,
  output logic [CNT_W-1:0] cnt
);
  logic s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= 1'b1;
      s2  <= 1'b1;
      cnt <= '0;
    end else begin
      s1 <= req;
      s2 <= s1;
      if (s2) cnt <= '0;
      else if (cnt != CNT_W'(CNT_END)) cnt <= cnt + 1'b1;
    end
  end

  assign held = s2;
  assign run  = !s2 && (cnt == CNT_W'(CNT_END));
endmodule

// File: rtl/dsync_chdiv.sv
module dsync_chdiv
  import dsync_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              clk_out
);
  logic [CODE_W:0] n_work, phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_work  <= (CODE_W+1)'(2);
      phase   <= '0;
      clk_out <= 1'b0;
    end else if (!run) begin
      n_work  <= div_len(code);
      phase   <= '0;
      clk_out <= 1'b0;
    end else begin
      clk_out <= (phase < high_len(n_work));
      phase   <= (phase == n_work - 1'b1) ? '0 : phase + 1'b1;
    end
  end
endmodule

// File: rtl/dsync_ctrl.sv
module dsync_ctrl
  import dsync_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int SYNC_LAT = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic              pd_n,
  input  logic              cal_busy,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NCH-1:0]    divclk
);
  localparam int CNT_END = SYNC_LAT - 3;
  localparam int CNT_W   = $clog2(CNT_END + 1);

  logic                  soft_sync, dist_pd, soft_rst, upd_pend;
  logic [NCH*CODE_W-1:0] ratio_code;
  logic                  sync_req, sync_held, div_run;
  logic [CNT_W-1:0]      rel_cnt;

  dsync_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .soft_sync(soft_sync), .dist_pd(dist_pd), .soft_rst(soft_rst),
    .ratio_code(ratio_code), .upd_pend(upd_pend)
  );

  assign sync_req = !sync_n | !pd_n | cal_busy | soft_sync | dist_pd | soft_rst;

  dsync_release #(.SYNC_LAT(SYNC_LAT), .CNT_END(CNT_END), .CNT_W(CNT_W)) u_rel (
    .clk(clk), .rst_n(rst_n), .req(sync_req),
    .held(sync_held), .run(div_run), .cnt(rel_cnt)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dsync_chdiv u_div (
      .clk(clk), .rst_n(rst_n), .run(div_run),
      .code(ratio_code[ch*CODE_W +: CODE_W]), .clk_out(divclk[ch])
    );
  end
endmodule

// File: rtl/dsync_chk.sv
module dsync_chk
  import dsync_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int CNT_END = 12,
  parameter int CNT_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              held,
  input logic              run,
  input logic [CNT_W-1:0]  cnt,
  input logic              upd_pend,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [NCH-1:0]    divclk
);
  p_static_when_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> (divclk == '0));

  p_no_run_while_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !run);

  p_release_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && cnt != CNT_W'(CNT_END)) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  p_aligned_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |=> (divclk == {NCH{1'b1}}));

  p_update_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pend && !(wr_en && wr_addr == A_UPD && wr_data[B_UPD])) |=> !upd_pend);
endmodule

bind dsync_ctrl dsync_chk #(.NCH(NCH), .CNT_END(CNT_END), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .held(sync_held), .run(div_run), .cnt(rel_cnt),
  .upd_pend(upd_pend), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .divclk(divclk)
);

// File: tb/tb_dsync_ctrl.sv
module tb_dsync_ctrl;
  localparam int NCH = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n, sync_n, pd_n, cal_busy, wr_en;
  logic [9:0]     wr_addr;
  logic [7:0]     wr_data;
  logic [NCH-1:0] divclk;

  dsync_ctrl #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .pd_n(pd_n), .cal_busy(cal_busy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .divclk(divclk)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit sh_srst, sh_sync, sh_pd, ac_srst, ac_sync, ac_pd, pend;
  int sh_code[NCH], ac_code[NCH], lat_n[NCH];
  bit rq[$];
  int quiet;
  logic [NCH-1:0] exp_clk;

  function automatic int ratio_of(input int code);
    return (code == 0) ? 2 : code + 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sh_srst, sh_sync, sh_pd, ac_srst, ac_sync, ac_pd, pend} = '0;
      for (int c = 0; c < NCH; c++) begin sh_code[c] = 0; ac_code[c] = 0; lat_n[c] = 2; end
      rq = {1'b1, 1'b1};
      quiet = 0;
      exp_clk = '0;
    end else begin
      bit req, dq, newpend;
      req = !sync_n || !pd_n || cal_busy || ac_srst || ac_sync || ac_pd;
      dq = rq.pop_front();
      rq.push_back(req);
      for (int c = 0; c < NCH; c++) if (quiet < 12) lat_n[c] = ratio_of(ac_code[c]);
      quiet = dq ? 0 : quiet + 1;
      for (int c = 0; c < NCH; c++)
        exp_clk[c] = (quiet >= 13) && (((quiet - 13) % lat_n[c]) < (lat_n[c] + 1) / 2);
      if (pend) begin
        ac_srst = sh_srst; ac_sync = sh_sync; ac_pd = sh_pd;
        for (int c = 0; c < NCH; c++) ac_code[c] = sh_code[c];
      end
      newpend = wr_en && wr_addr == 10'h232 && wr_data[0];
      if (wr_en && wr_addr == 10'h230) begin sh_sync = wr_data[0]; sh_pd = wr_data[1]; end
      if (wr_en && wr_addr == 10'h000) sh_srst = wr_data[2];
      for (int c = 0; c < NCH; c++)
        if (wr_en && wr_addr == 10'h100 + c) sh_code[c] = int'(wr_data[4:0]);
      pend = newpend;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (divclk !== exp_clk) begin
        fails++;
        $display("FAIL %s per-cycle model actual=%0d expected=%0d",
                 (exp_clk == '0) ? "R1" : "R5", divclk, exp_clk);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic commit();
    wr(10'h232, 8'h01);
  endtask

  task automatic wait_start(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (divclk == '0 && n < 100);
  endtask

  task automatic count_rises(input int ch, input int cyc, output int r);
    logic prev;
    r = 0;
    prev = divclk[ch];
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (divclk[ch] && !prev) r++;
      prev = divclk[ch];
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n, r;
    rst_n = 1'b0; sync_n = 1'b1; pd_n = 1'b1; cal_busy = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    idle(3);
    chk(divclk == '0, "R2 outputs low in reset", divclk, 0);

    // reset release is a sync event
    @(negedge clk); rst_n = 1'b1;
    wait_start(n);
    chk(n == 15, "R2 start after reset release (negedges)", n, 15);
    chk(divclk == '1, "R4 all channels rise together after reset", divclk, 15);
    count_rises(0, 40, r);
    chk(r == 20, "R5 default divide-by-2 rises in 40", r, 20);

    // new ratios committed while running: no effect yet
    wr(10'h100, 8'h00); wr(10'h101, 8'h02); wr(10'h102, 8'h04); wr(10'h103, 8'h1F);
    commit();
    count_rises(3, 64, r);
    chk(r == 32, "R8 running channel keeps old ratio", r, 32);

    // sync pin pulse
    @(negedge clk); sync_n = 1'b0;
    idle(6);
    chk(divclk == '0, "R1 outputs static while sync pin low", divclk, 0);
    @(negedge clk); sync_n = 1'b1;
    wait_start(n);
    chk(n == 15, "R3 latency from sync pin rise (negedges)", n, 15);
    chk(divclk == '1, "R4 aligned first edge after sync", divclk, 15);
    count_rises(1, 60, r);
    chk(r == 20, "R5 divide-by-3 rises in 60", r, 20);
    count_rises(2, 60, r);
    chk(r == 12, "R5 divide-by-5 rises in 60", r, 12);
    count_rises(3, 64, r);
    chk(r == 2, "R8 divide-by-32 loaded at sync", r, 2);

    // soft sync bit: shadow write alone does nothing
    wr(10'h230, 8'h01);
    count_rises(0, 20, r);
    chk(r == 10, "R6 shadow soft sync has no effect", r, 10);
    commit();
    idle(6);
    chk(divclk == '0, "R6 committed soft sync holds outputs", divclk, 0);
    wr(10'h230, 8'h00);
    idle(4);
    chk(divclk == '0, "R6 shadow clear alone keeps hold", divclk, 0);
    commit();
    wait_start(n);
    chk(n == 16, "R6 restart after committed clear (negedges)", n, 16);

    // strobe self-clears: later shadow write stays inactive
    wr(10'h230, 8'h01);
    count_rises(0, 20, r);
    chk(r == 10, "R7 strobe cleared, new shadow ignored", r, 10);
    wr(10'h230, 8'h00);

    // soft reset bit
    wr(10'h000, 8'h04); commit();
    idle(6);
    chk(divclk == '0, "R6 soft reset bit holds outputs", divclk, 0);
    wr(10'h000, 8'h00); commit();
    wait_start(n);
    chk(n == 16, "R6 restart after soft reset clear", n, 16);

    // distribution power-down bit
    wr(10'h230, 8'h02); commit();
    idle(6);
    chk(divclk == '0, "R6 distribution power-down holds outputs", divclk, 0);
    wr(10'h230, 8'h00); commit();
    wait_start(n);
    chk(n == 16, "R6 restart after power-down bit clear", n, 16);

    // unrelated bits and addresses
    wr(10'h230, 8'hFC); wr(10'h231, 8'hFF); commit();
    count_rises(0, 20, r);
    chk(r == 10, "R10 other bits and addresses ignored", r, 10);
    wr(10'h230, 8'h00); commit();

    // power-down pin
    @(negedge clk); pd_n = 1'b0;
    idle(5);
    chk(divclk == '0, "R1 outputs static while power-down pin low", divclk, 0);
    @(negedge clk); pd_n = 1'b1;
    wait_start(n);
    chk(n == 15, "R1 latency from power-down pin release", n, 15);

    // calibration, overlapping with the sync pin
    @(negedge clk); cal_busy = 1'b1; sync_n = 1'b0;
    idle(5);
    @(negedge clk); sync_n = 1'b1;
    idle(25);
    chk(divclk == '0, "R9 calibration still holds after sync pin release", divclk, 0);
    @(negedge clk); cal_busy = 1'b0;
    wait_start(n);
    chk(n == 15, "R9 latency from calibration end", n, 15);
    chk(divclk == '1, "R4 aligned after calibration", divclk, 15);
    idle(40);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule